// File: doc/BRIEF.md
# Parallel Converter Bus Master

This block sits on the host side of a data converter that shares one three-state parallel port for configuration writes and result reads. A request carries a channel number, a range bit, a polarity bit, a two-bit power/clock setting and an acquisition-mode flag. The block packs these into a control byte and writes it with an active-low chip select and write strobe. It then waits for the converter's active-low completion flag and reads the 12-bit result with the read strobe. The result comes back with a one-cycle valid pulse.

When externally timed acquisition is requested, two writes go out. The first opens an acquisition window. After a programmable hold-off, the second write closes the window and starts conversion. Strobe widths, data setup and bus turnaround are given in nanoseconds and turned into system-clock counts, rounded up. A watchdog on the completion wait ends a transaction that gets no answer and reports it with an error pulse.

The data bus is split into a drive value, a drive enable and a sampled input. The pad ring or a wrapper joins them into one bidirectional bus.

Top module: `adc_bus_master`

## Requirements
- R1: While reset is asserted, chip select, write and read strobes are high, the bus is not driven, req_ready is high and neither res_valid nor res_timeout is asserted.
- R2: The control byte appears on db_out[7:0] as power setting in bits 7:6, acquisition flag in bit 5, range in bit 4, polarity in bit 3 and channel in bits 2:0, with db_out[11:8] zero.
- R3: Each write holds wr_n low for exactly ceil(max(WR_NS,SETUP_NS)/CLK_NS) cycles (8 at 10 ns) with the byte driven throughout. The byte and db_oe stay unchanged for one more cycle after wr_n rises.
- R4: cs_n is low during every cycle in which wr_n or rd_n is low.
- R5: A request with the acquisition flag clear produces exactly one write, then a wait for int_n low, then exactly one read. The read starts only while int_n is low.
- R6: A request with the acquisition flag set produces two writes with the same channel. The first carries bit 5 = 1 and the second bit 5 = 0. Between them wr_n and cs_n stay high for exactly holdoff+1 full cycles after the cycle in which wr_n rose.
- R7: rd_n stays low for exactly ceil(RD_NS/CLK_NS) cycles (12 at 10 ns). The bus value in the last of those cycles is returned on res_data with res_valid high for one cycle.
- R8: After rd_n rises, db_oe stays low and req_ready stays low for ceil(REL_NS/CLK_NS) cycles (7 at 10 ns).
- R9: db_oe is never high while rd_n is low, and wr_n and rd_n are never low together.
- R10: If int_n does not go low within TMO_CYC cycles of the wait, res_timeout pulses for one cycle, no read is issued and req_ready returns.
- R11: req_valid asserted while req_ready is low has no effect: no extra write occurs and the pending result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | 3 | Converter input channel |
| req_range | input | 1 | Full-scale range select |
| req_bipolar | input | 1 | Bipolar (1) or unipolar (0) coding |
| req_pwr | input | 2 | Power-down / clock-source setting |
| req_ext_acq | input | 1 | 1 = two-write externally timed acquisition |
| req_holdoff | input | CW | Hold-off between the two writes, cycles minus one |
| res_valid | output | 1 | One-cycle pulse, res_data valid |
| res_data | output | 12 | Conversion result read from the bus |
| res_timeout | output | 1 | One-cycle pulse, completion wait expired |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| db_oe | output | 1 | Host drives the data bus when high |
| db_out | output | 12 | Value driven on the data bus |
| db_in | input | 12 | Value sampled from the data bus |
| int_n | input | 1 | Converter completion flag, active low |

## Verification
A wrong state or counter shows at the strobe pins within one cycle. A write or read one cycle short or long, a cs_n that rises early, or a drive enable that comes back during turnaround is seen by the converter model as soon as the strobe edge it measures occurs. A mis-packed or stale configuration byte is found at the rising edge of the write that carries it. A read that samples too early returns the model's placeholder value instead of the result, so the error surfaces on res_data at the res_valid pulse. Losing track of the two-write sequence shows as a wrong write count, a wrong acquisition bit or a wrong hold-off gap before that transaction completes.

// File: rtl/adc_bus_master.sv
module adc_bus_master #(
  parameter int CLK_NS   = 10,
  parameter int WR_NS    = 80,
  parameter int SETUP_NS = 60,
  parameter int RD_NS    = 120,
  parameter int REL_NS   = 70,
  parameter int CW       = 16,
  parameter int TMO_CYC  = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_chan,
  input  logic          req_range,
  input  logic          req_bipolar,
  input  logic [1:0]    req_pwr,
  input  logic          req_ext_acq,
  input  logic [CW-1:0] req_holdoff,
  output logic          res_valid,
  output logic [11:0]   res_data,
  output logic          res_timeout,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rd_n,
  output logic          db_oe,
  output logic [11:0]   db_out,
  input  logic [11:0]   db_in,
  input  logic          int_n
);

  localparam int WLO_NS  = (WR_NS > SETUP_NS) ? WR_NS : SETUP_NS;
  localparam int WR_RAW  = (WLO_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_RAW  = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int REL_RAW = (REL_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC  = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int REL_CYC = (REL_RAW < 1) ? 1 : REL_RAW;
  localparam int TMO_USE = (TMO_CYC < 1) ? 1 : TMO_CYC;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_HOLD, S_WAIT, S_RD, S_REL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold;
  logic [7:0]    cfg;
  logic          first;
  logic [1:0]    int_sync;

  wire cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      hold        <= '0;
      cfg         <= '0;
      first       <= 1'b0;
      int_sync    <= 2'b11;
      res_valid   <= 1'b0;
      res_timeout <= 1'b0;
      res_data    <= '0;
    end else begin
      int_sync    <= {int_sync[0], int_n};
      res_valid   <= 1'b0;
      res_timeout <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            cfg   <= {req_pwr, req_ext_acq, req_range, req_bipolar, req_chan};
            first <= req_ext_acq;
            hold  <= req_holdoff;
            cnt   <= CW'(WR_CYC - 1);
            st    <= S_WLO;
          end
        S_WLO:
          if (cnt_done) st <= S_WHI;
          else cnt <= cnt - 1'b1;
        S_WHI:
          if (first) begin
            first  <= 1'b0;
            cfg[5] <= 1'b0;
            cnt    <= hold;
            st     <= S_HOLD;
          end else begin
            cnt <= CW'(TMO_USE - 1);
            st  <= S_WAIT;
          end
        S_HOLD:
          if (cnt_done) begin
            cnt <= CW'(WR_CYC - 1);
            st  <= S_WLO;
          end else cnt <= cnt - 1'b1;
        S_WAIT:
          if (!int_sync[1]) begin
            cnt <= CW'(RD_CYC - 1);
            st  <= S_RD;
          end else if (cnt_done) begin
            res_timeout <= 1'b1;
            st          <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        S_RD:
          if (cnt_done) begin
            res_data  <= db_in;
            res_valid <= 1'b1;
            cnt       <= CW'(REL_CYC - 1);
            st        <= S_REL;
          end else cnt <= cnt - 1'b1;
        S_REL:
          if (cnt_done) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign wr_n      = (st != S_WLO);
  assign rd_n      = (st != S_RD);
  assign cs_n      = !(st == S_WLO || st == S_WHI || st == S_RD);
  assign db_oe     = (st == S_WLO || st == S_WHI);
  assign db_out    = {4'b0000, cfg};

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> db_oe && $stable(db_out));
  // R4
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !db_oe && wr_n);
  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !db_oe && !req_ready);
  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R10
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_timeout |-> !res_valid && req_ready && rd_n);
  // R10
  tmo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_timeout |=> !res_timeout);

endmodule

// File: tb/adc_bus_master_test.sv
module adc_bus_master_test;
  localparam int TCK  = 10;
  localparam int TMO  = 300;
  localparam int CONV = 40;
  localparam int EWR  = 8;
  localparam int ERD  = 12;
  localparam int EREL = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_chan = '0;
  logic        req_range = 1'b0, req_bipolar = 1'b0, req_ext_acq = 1'b0;
  logic [1:0]  req_pwr = '0;
  logic [15:0] req_holdoff = '0;
  logic        res_valid, res_timeout;
  logic [11:0] res_data;
  logic        cs_n, wr_n, rd_n, db_oe;
  logic [11:0] db_out;
  logic [11:0] db_in = 12'hFFF;
  logic        int_n = 1'b1;

  int checks = 0;
  int errors = 0;

  adc_bus_master #(.CLK_NS(TCK), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_range(req_range), .req_bipolar(req_bipolar),
    .req_pwr(req_pwr), .req_ext_acq(req_ext_acq), .req_holdoff(req_holdoff),
    .res_valid(res_valid), .res_data(res_data), .res_timeout(res_timeout),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .db_oe(db_oe), .db_out(db_out),
    .db_in(db_in), .int_n(int_n));

  always #(TCK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // converter model state
  logic [7:0]  exp_q[$];
  logic [11:0] conv_result = '0;
  bit          no_answer = 0;
  int          exp_hold = 0;
  int          wr_falls = 0, rd_falls = 0;
  int          wr_low = 0, rd_low = 0, since_rd = 100, gap = 0, conv_left = -1;
  bit          acq_open = 0;
  logic [2:0]  acq_chan = '0;
  logic        prev_wr = 1'b1, prev_rd = 1'b1;
  int          seen_valid = 0, seen_tmo = 0;
  logic [11:0] seen_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      // write side
      if (!wr_n) begin
        if (prev_wr) begin
          wr_falls++;
          if (acq_open) chk(gap == exp_hold + 1, "R6 hold-off gap", gap, exp_hold + 1);
          int_n = 1'b1;
        end
        wr_low++;
        chk(db_oe == 1'b1, "R3 drive while wr low", db_oe, 1);
        chk(cs_n == 1'b0, "R4 cs during write", cs_n, 0);
      end else if (!prev_wr) begin
        logic [7:0] eb;
        chk(wr_low == EWR, "R3 write width", wr_low, EWR);
        chk(db_oe == 1'b1, "R3 hold after rise", db_oe, 1);
        chk(db_out[11:8] == 4'h0, "R2 upper lines zero", db_out[11:8], 0);
        eb = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(db_out[7:0] === eb, "R2 control byte", db_out[7:0], eb);
        if (db_out[5]) begin
          acq_open = 1;
          acq_chan = db_out[2:0];
          gap = 0;
        end else begin
          if (acq_open) chk(db_out[2:0] == acq_chan, "R6 same channel", db_out[2:0], acq_chan);
          acq_open = 0;
          conv_left = no_answer ? -1 : CONV;
        end
        wr_low = 0;
      end else if (acq_open) begin
        gap++;
        chk(cs_n == 1'b1, "R6 cs high in hold-off", cs_n, 1);
      end
      // conversion
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) int_n = 1'b0;
      end
      // read side
      if (!rd_n) begin
        if (prev_rd) begin
          rd_falls++;
          chk(int_n == 1'b0, "R5 read only after completion", int_n, 0);
        end
        rd_low++;
        int_n = 1'b1;
        chk(cs_n == 1'b0, "R4 cs during read", cs_n, 0);
        chk(db_oe == 1'b0 && wr_n, "R9 no contention", db_oe, 0);
        db_in = (rd_low >= ERD) ? conv_result : 12'hBAD;
      end else begin
        if (!prev_rd) begin
          chk(rd_low == ERD, "R7 read width", rd_low, ERD);
          since_rd = 0;
          rd_low = 0;
        end
        since_rd++;
        if (since_rd <= EREL) begin
          chk(db_oe == 1'b0, "R8 bus released", db_oe, 0);
          chk(req_ready == 1'b0, "R8 ready held off", req_ready, 0);
        end
        db_in = 12'hFFF;
      end
      if (res_valid) begin
        seen_valid++;
        seen_data = res_data;
      end
      if (res_timeout) seen_tmo++;
      prev_wr = wr_n;
      prev_rd = rd_n;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_req(input logic [2:0] ch, input logic rng, input logic bip,
                         input logic [1:0] pw, input logic ext, input int hold,
                         input logic [11:0] result, input bit silent, input bit poke);
    int wf0, rf0, v0, t0;
    logic [7:0] b;
    b = {pw, ext, rng, bip, ch};
    exp_q.push_back(b);
    if (ext) exp_q.push_back({pw, 1'b0, rng, bip, ch});
    conv_result = result;
    no_answer = silent;
    exp_hold = hold;
    wf0 = wr_falls; rf0 = rd_falls; v0 = seen_valid; t0 = seen_tmo;
    @(negedge clk);
    req_chan = ch; req_range = rng; req_bipolar = bip; req_pwr = pw;
    req_ext_acq = ext; req_holdoff = 16'(hold); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      // R11: stray request while busy
      req_chan = ~ch; req_ext_acq = 1'b0; req_valid = 1'b1;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (seen_valid != v0 || seen_tmo != t0) break;
      @(negedge clk);
    end
    for (int i = 0; i < 50; i++) begin
      if (req_ready) break;
      @(negedge clk);
    end
    if (silent) begin
      chk(seen_tmo == t0 + 1, "R10 timeout pulse", seen_tmo - t0, 1);
      chk(rd_falls == rf0, "R10 no read on timeout", rd_falls - rf0, 0);
      chk(seen_valid == v0, "R10 no result on timeout", seen_valid - v0, 0);
    end else begin
      chk(seen_valid == v0 + 1, "R7 one result", seen_valid - v0, 1);
      chk(seen_data == result, "R7 result data", seen_data, result);
      chk(rd_falls == rf0 + 1, "R5 one read", rd_falls - rf0, 1);
    end
    chk(wr_falls == wf0 + (ext ? 2 : 1), poke ? "R11 no extra write" : (ext ? "R6 two writes" : "R5 one write"),
        wr_falls - wf0, ext ? 2 : 1);
    chk(req_ready == 1'b1, "R8 ready after transaction", req_ready, 1);
    chk(exp_q.size() == 0, "R2 all bytes written", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n && wr_n && rd_n, "R1 strobes high in reset", {cs_n, wr_n, rd_n}, 3'b111);
    chk(!db_oe, "R1 bus idle in reset", db_oe, 0);
    chk(req_ready && !res_valid && !res_timeout, "R1 ready, no pulses", {req_ready, res_valid, res_timeout}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_req(3'd3, 1'b1, 1'b0, 2'b01, 1'b0, 0, 12'h5A3, 0, 0);
    run_req(3'd5, 1'b1, 1'b1, 2'b10, 1'b1, 5, 12'h800, 0, 0);
    run_req(3'd2, 1'b0, 1'b1, 2'b00, 1'b1, 0, 12'h7FF, 0, 0);
    run_req(3'd1, 1'b0, 1'b0, 2'b11, 1'b0, 0, 12'h000, 1, 0);
    run_req(3'd4, 1'b1, 1'b0, 2'b00, 1'b0, 0, 12'h3C5, 0, 1);
    run_req(3'd0, 1'b0, 1'b0, 2'b11, 1'b0, 0, 12'hFFF, 0, 0);
    run_req(3'd7, 1'b1, 1'b1, 2'b01, 1'b1, 17, 12'h001, 0, 0);
    repeat (5) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule